// File: doc/BRIEF.md
# Timer Interrupt Status and Routing Stage

This block is the interrupt-generation stage of a multi-timer event controller. It sits after the comparator match logic. Each timer supplies a one-cycle fire strobe and a small configuration: an enable, a level/edge select and a route field. A global enable and a legacy-mode switch are shared by all timers. From these inputs the block keeps a per-timer interrupt status register and drives a bank of interrupt lines.

A timer in level mode latches its status bit when it fires and holds its routed line high until software clears the bit. It clears the bit with a write-one-to-clear write through a simple strobe and data port. A timer in edge mode produces a single-cycle pulse on its routed line and leaves its status bit clear. Legacy mode moves timers 0 and 1 onto fixed lines. All outputs are registered, and status and lines change at the same clock edge that samples the inputs.

Top module: `tmr_irq_ctl`

## Requirements
- R1: A synchronous reset clears every status bit and drives every interrupt line low at the next clock edge.
- R2: A fire on timer t in level mode (level select = 1) sets status bit t and drives its routed line high. This happens only when the timer's enable was 1 in the previous cycle and the global enable is 1. Bit and line then hold until cleared.
- R3: A fire on an enabled timer in edge mode (level select = 0) clears status bit t and drives its routed line high for exactly one cycle.
- R4: A fire while the timer's enable was 0 in the previous cycle, or while the global enable is 0, clears status bit t and produces no line activity.
- R5: A status write clears every status bit that is 1 both in the write data (bit t for timer t) and in the current status, and the corresponding line falls at the same edge.
- R6: Write-data ones at bit positions whose status bit is 0 change neither the status nor any line.
- R7: When a timer's enable goes from 1 to 0, its status bit clears and its line falls at the next edge.
- R8: When legacy mode is 1, timer 0 drives line 0 and timer 1 drives line 8 whatever their route fields hold. Other timers, and all timers with legacy mode 0, drive the line whose index is their route field. A route value of 24 or more drives no line.
- R9: Timers routed to the same line share it: the line is the OR of their held levels and pulses.
- R10: A fire in the same cycle as the timer's enable rising is handled as if the timer were disabled, because the enable sampled one cycle earlier decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fire_i | input | N_TMR | Per-timer fire strobe, bit t = timer t |
| tmr_en_i | input | N_TMR | Per-timer enable |
| tmr_lvl_i | input | N_TMR | Per-timer mode: 1 level, 0 edge |
| tmr_route_i | input | N_TMR*RW | Route fields, timer t at bits [t*RW +: RW] |
| glb_en_i | input | 1 | Global enable |
| legacy_i | input | 1 | Legacy routing for timers 0 and 1 |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | N_TMR | Write-one-to-clear data |
| sts_o | output | N_TMR | Interrupt status register |
| irq_o | output | N_LINES | Interrupt lines |

## Verification
A wrong status bit shows on irq_o at the same edge as on sts_o, because each line is built from the next-state status. A stuck bit therefore keeps its line high through a later clear or deactivation, and a lost bit leaves the line low right after the fire. A wrong pulse length or a wrong route decode shows one cycle after the fire as a line that is high when it should be low, or high on the wrong index. The tests include fires whose enable rises in the same cycle, and clears aimed at bits that are not set, so that a wrong priority among fire, deactivation and clear shows on the ports within one cycle.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  // next-state view of one timer, handed to the router
  typedef struct packed {
    logic sts;
    logic pulse;
  } slot_nx_t;

endpackage

// File: rtl/tmr_irq_slot.sv
module tmr_irq_slot
  import tmr_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fire,
  input  logic     en,
  input  logic     lvl,
  input  logic     glb_en,
  input  logic     clr,
  output logic     sts_q,
  output slot_nx_t nx
);

  logic en_q;
  logic deact;
  logic armed;

  assign deact = en_q & ~en;
  assign armed = en_q & glb_en;

  // priority: deactivation, then fire, then software clear
  always_comb begin
    nx.sts   = sts_q;
    nx.pulse = 1'b0;
    if (deact) begin
      nx.sts = 1'b0;
    end else if (fire) begin
      if (armed && lvl) begin
        nx.sts = 1'b1;
      end else begin
        nx.sts   = 1'b0;
        nx.pulse = armed & ~lvl;
      end
    end else if (clr) begin
      nx.sts = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      en_q  <= en;
      sts_q <= nx.sts;
    end
  end

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router #(
  parameter int N_TMR   = 3,
  parameter int N_LINES = 24,
  parameter int RW      = 5,
  parameter int LEG0    = 0,
  parameter int LEG1    = 8
) (
  input  logic                 legacy,
  input  logic [N_TMR*RW-1:0]  route,
  input  logic [N_TMR-1:0]     act,
  output logic [N_LINES-1:0]   lines
);

  logic [RW-1:0] sel [N_TMR];

  for (genvar t = 0; t < N_TMR; t++) begin : g_sel
    if (t == 0) begin : g_leg0
      assign sel[t] = legacy ? RW'(LEG0) : route[t*RW +: RW];
    end else if (t == 1) begin : g_leg1
      assign sel[t] = legacy ? RW'(LEG1) : route[t*RW +: RW];
    end else begin : g_cfg
      assign sel[t] = route[t*RW +: RW];
    end
  end

  always_comb begin
    lines = '0;
    for (int t = 0; t < N_TMR; t++) begin
      for (int l = 0; l < N_LINES; l++) begin
        if (sel[t] == RW'(l)) lines[l] = lines[l] | act[t];
      end
    end
  end

endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
  import tmr_irq_pkg::*;
#(
  parameter int N_TMR   = 3,
  parameter int N_LINES = 24,
  parameter int LEG0    = 0,
  parameter int LEG1    = 8,
  localparam int RW     = $clog2(N_LINES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_TMR-1:0]    fire_i,
  input  logic [N_TMR-1:0]    tmr_en_i,
  input  logic [N_TMR-1:0]    tmr_lvl_i,
  input  logic [N_TMR*RW-1:0] tmr_route_i,
  input  logic                glb_en_i,
  input  logic                legacy_i,
  input  logic                sts_wr_i,
  input  logic [N_TMR-1:0]    sts_wdata_i,
  output logic [N_TMR-1:0]    sts_o,
  output logic [N_LINES-1:0]  irq_o
);

  slot_nx_t             nx [N_TMR];
  logic [N_TMR-1:0]     act;
  logic [N_LINES-1:0]   lines_nx;

  for (genvar t = 0; t < N_TMR; t++) begin : g_slot
    tmr_irq_slot u_slot (
      .clk    (clk),
      .rst    (rst),
      .fire   (fire_i[t]),
      .en     (tmr_en_i[t]),
      .lvl    (tmr_lvl_i[t]),
      .glb_en (glb_en_i),
      .clr    (sts_wr_i & sts_wdata_i[t]),
      .sts_q  (sts_o[t]),
      .nx     (nx[t])
    );
    assign act[t] = nx[t].sts | nx[t].pulse;
  end

  tmr_irq_router #(
    .N_TMR   (N_TMR),
    .N_LINES (N_LINES),
    .RW      (RW),
    .LEG0    (LEG0),
    .LEG1    (LEG1)
  ) u_router (
    .legacy (legacy_i),
    .route  (tmr_route_i),
    .act    (act),
    .lines  (lines_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= lines_nx;
  end

endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
  parameter int N_TMR   = 3,
  parameter int N_LINES = 24
) (
  input logic               clk,
  input logic               rst,
  input logic [N_TMR-1:0]   fire_i,
  input logic [N_TMR-1:0]   tmr_en_i,
  input logic [N_TMR-1:0]   tmr_lvl_i,
  input logic               glb_en_i,
  input logic               sts_wr_i,
  input logic [N_TMR-1:0]   sts_wdata_i,
  input logic [N_TMR-1:0]   sts_o,
  input logic [N_LINES-1:0] irq_o
);

  logic [N_TMR-1:0] en_d;

  always_ff @(posedge clk) begin
    if (rst) en_d <= '0;
    else     en_d <= tmr_en_i;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (sts_o == '0 && irq_o == '0));

  for (genvar t = 0; t < N_TMR; t++) begin : g_t
    a_r2_level_sets: assert property (@(posedge clk) disable iff (rst)
      (fire_i[t] && en_d[t] && tmr_en_i[t] && glb_en_i && tmr_lvl_i[t]) |=> sts_o[t]);

    a_r3_edge_no_status: assert property (@(posedge clk) disable iff (rst)
      (fire_i[t] && !tmr_lvl_i[t]) |=> !sts_o[t]);

    a_r4_off_clears: assert property (@(posedge clk) disable iff (rst)
      (fire_i[t] && !(en_d[t] && glb_en_i)) |=> !sts_o[t]);

    a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
      (sts_wr_i && sts_wdata_i[t] && !fire_i[t]) |=> !sts_o[t]);

    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
      (!sts_o[t] && !fire_i[t]) |=> !sts_o[t]);

    a_r7_deact_clears: assert property (@(posedge clk) disable iff (rst)
      (en_d[t] && !tmr_en_i[t]) |=> !sts_o[t]);
  end

endmodule

bind tmr_irq_ctl tmr_irq_chk #(
  .N_TMR   (N_TMR),
  .N_LINES (N_LINES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fire_i      (fire_i),
  .tmr_en_i    (tmr_en_i),
  .tmr_lvl_i   (tmr_lvl_i),
  .glb_en_i    (glb_en_i),
  .sts_wr_i    (sts_wr_i),
  .sts_wdata_i (sts_wdata_i),
  .sts_o       (sts_o),
  .irq_o       (irq_o)
);

// File: tb/tmr_irq_ctl_tb.sv
module tmr_irq_ctl_tb;

  localparam int NT = 3;
  localparam int NL = 24;
  localparam int RW = 5;

  typedef struct packed {
    logic [2:0]  fire;
    logic [2:0]  en;
    logic [2:0]  lvl;
    logic        glb;
    logic        leg;
    logic        wr;
    logic [2:0]  wd;
    logic [2:0]  sts;
    logic [23:0] irq;
  } vec_t;

  // routes during the table: timer0 -> 3, timer1 -> 5, timer2 -> 7
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'b000, 3'b111, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000, 24'h000000},
    '{3'b001, 3'b111, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000, 3'b001, 24'h000008},
    '{3'b000, 3'b111, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000, 3'b001, 24'h000008},
    '{3'b010, 3'b111, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000, 3'b001, 24'h000028},
    '{3'b000, 3'b111, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000, 3'b001, 24'h000008},
    '{3'b000, 3'b111, 3'b001, 1'b1, 1'b0, 1'b1, 3'b110, 3'b001, 24'h000008},
    '{3'b000, 3'b111, 3'b001, 1'b1, 1'b0, 1'b1, 3'b001, 3'b000, 24'h000000},
    '{3'b100, 3'b111, 3'b101, 1'b1, 1'b0, 1'b0, 3'b000, 3'b100, 24'h000080},
    '{3'b000, 3'b011, 3'b101, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000, 24'h000000},
    '{3'b100, 3'b011, 3'b101, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000, 24'h000000},
    '{3'b001, 3'b111, 3'b101, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 24'h000000},
    '{3'b001, 3'b111, 3'b101, 1'b1, 1'b1, 1'b0, 3'b000, 3'b001, 24'h000001},
    '{3'b010, 3'b111, 3'b101, 1'b1, 1'b1, 1'b0, 3'b000, 3'b001, 24'h000101},
    '{3'b100, 3'b111, 3'b101, 1'b1, 1'b1, 1'b0, 3'b000, 3'b101, 24'h000081},
    '{3'b000, 3'b111, 3'b101, 1'b1, 1'b0, 1'b0, 3'b000, 3'b101, 24'h000088},
    '{3'b000, 3'b111, 3'b101, 1'b1, 1'b0, 1'b1, 3'b111, 3'b000, 24'h000000}
  };

  string tag [NV] = '{"R2", "R2", "R2", "R3", "R3", "R6", "R5", "R2",
                      "R7", "R4", "R4", "R8", "R8", "R8", "R8", "R5"};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NT-1:0]    fire = '0, en = '0, lvl = '0, wd = '0;
  logic             glb = 1'b0, leg = 1'b0, wr = 1'b0;
  logic [RW-1:0]    r0 = 5'd3, r1 = 5'd5, r2 = 5'd7;
  logic [NT-1:0]    sts;
  logic [NL-1:0]    irq;
  int               n_run = 0;
  int               n_fail = 0;

  always #5 clk = ~clk;

  tmr_irq_ctl u_dut (
    .clk         (clk),
    .rst         (rst),
    .fire_i      (fire),
    .tmr_en_i    (en),
    .tmr_lvl_i   (lvl),
    .tmr_route_i ({r2, r1, r0}),
    .glb_en_i    (glb),
    .legacy_i    (leg),
    .sts_wr_i    (wr),
    .sts_wdata_i (wd),
    .sts_o       (sts),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive after a falling edge, clock once, sample at the next falling edge
  task automatic step(input logic [2:0] f, input logic w, input logic [2:0] d);
    fire = f; wr = w; wd = d;
    @(posedge clk);
    @(negedge clk);
    fire = '0; wr = 1'b0; wd = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset status", 24'(sts), 24'h0);
    chk("R1 reset lines", irq, 24'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      en = VEC[i].en; lvl = VEC[i].lvl; glb = VEC[i].glb; leg = VEC[i].leg;
      step(VEC[i].fire, VEC[i].wr, VEC[i].wd);
      chk({tag[i], " status"}, 24'(sts), 24'(VEC[i].sts));
      chk({tag[i], " lines"}, irq, VEC[i].irq);
    end

    // R9: timer0 level and timer2 edge share line 3
    r2 = 5'd3; lvl = 3'b001;
    step(3'b101, 1'b0, 3'b000);
    chk("R9 shared set", irq, 24'h000008);
    step(3'b100, 1'b1, 3'b001);
    chk("R9 pulse keeps shared line", irq, 24'h000008);
    chk("R9 status cleared", 24'(sts), 24'h0);
    step(3'b000, 1'b0, 3'b000);
    chk("R9 line released", irq, 24'h000000);

    // R10: fire in the cycle the enable rises is ignored
    en = 3'b101; lvl = 3'b011;
    step(3'b000, 1'b0, 3'b000);
    en = 3'b111;
    step(3'b010, 1'b0, 3'b000);
    chk("R10 same-cycle enable status", 24'(sts), 24'h0);
    chk("R10 same-cycle enable line", irq, 24'h0);
    step(3'b010, 1'b0, 3'b000);
    chk("R10 fire after enable", irq, 24'h000020);

    // R8: out-of-range route drives nothing
    r2 = 5'd30; lvl = 3'b111;
    step(3'b100, 1'b0, 3'b000);
    chk("R8 out-of-range route", irq, 24'h000020);
    chk("R8 status still set", 24'(sts), 24'h6);

    // R1: reset mid-run with status set
    rst = 1'b1;
    step(3'b000, 1'b0, 3'b000);
    rst = 1'b0;
    chk("R1 reset status", 24'(sts), 24'h0);
    chk("R1 reset lines", irq, 24'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule